// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This unit watches the CPU's memory accesses and stops the processor when the address hits one of four programmed breakpoints. Each breakpoint is a 24-bit address. The debug side loads it one byte at a time through a small register write port. A separate control register switches each breakpoint on or off.

The unit first forms the effective address from the addressing mode. In linear mode this is the whole 24-bit bus. In compatibility mode it is an 8-bit base byte placed above the low 16 address bits. The unit compares the effective address against every enabled breakpoint.

A hit on the first opcode fetch of an instruction stops the CPU in the next cycle. A hit on any other access is held as pending, and the stop is issued only when the instruction ends. Once the break request is raised, the CPU is in debug mode. The request stays high until the debug side acknowledges it.

The register write port is a plain strobe. It has no back-pressure, and one write is accepted in every cycle in which the strobe is high. The access inputs are also plain strobes, sampled on each clock.

Top module: `addr_brk_unit`

## Requirements
- R1: Breakpoint set s (0..3) is written at register addresses 3s (bits 7:0), 3s+1 (bits 15:8) and 3s+2 (bits 23:16). Any byte value is accepted. A write changes only the byte it addresses.
- R2: Register address 0x0C is the control register. Bits 3:0 enable sets 0..3, and bits 7:4 are ignored. Writes to addresses 0x0D–0x0F have no effect.
- R3: With `mode_linear`=1, the compared address is `cpu_addr[23:0]`.
- R4: With `mode_linear`=0, the compared address is {`base_byte`, `cpu_addr[15:0]`}, and `cpu_addr[23:16]` is ignored.
- R5: A set whose enable bit is 0 never produces a break.
- R6: A hit with `acc_valid`=1 and `acc_first`=1 raises `brk_req` in the cycle after the access.
- R7: A hit with `acc_first`=0 is held as pending. `brk_req` rises in the cycle after `instr_end`, and a hit in the same cycle as `instr_end` counts for that instruction. The pending state is cleared when the break is issued.
- R8: One request is raised however many sets hit. When it is issued, `brk_hits` latches the OR of all sets that hit since the last issue. This includes the pending ones.
- R9: `brk_req` stays high, with `brk_hits` unchanged, until `dbg_ack`. It falls in the cycle after `dbg_ack`.
- R10: While `brk_req` is high, hits are ignored and not held as pending.
- R11: After reset, `brk_req`=0, `brk_hits`=0, all enables are 0 and no break is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register address |
| reg_wr_data | input | 8 | Register write data |
| mode_linear | input | 1 | 1 = 24-bit linear addressing, 0 = base + 16-bit |
| base_byte | input | 8 | Base byte used in compatibility mode |
| cpu_addr | input | 24 | CPU address bus |
| acc_valid | input | 1 | An access is on the bus this cycle |
| acc_first | input | 1 | The access is the first opcode fetch |
| instr_end | input | 1 | The current instruction completes this cycle |
| dbg_ack | input | 1 | Debug-side resume/acknowledge pulse |
| brk_req | output | 1 | Break request (CPU in debug mode) |
| brk_hits | output | 4 | Sets that caused the last break |

## Verification
The bench aims first at the deferred path. A design that issued a deferred hit at once would raise `brk_req` before `instr_end`. A design that dropped the pending bits would never raise it at all.

It checks compatibility mode with `cpu_addr[23:16]` set to garbage. A unit that compared the raw bus there would either miss the hit or match the wrong set.

It repeats matching accesses while a break is outstanding. A unit that did not ignore them would stack up a spurious second break after the acknowledge.

Several sets hitting together, and hits gathered across one instruction, expose a status value that was latched from only one set.

// File: rtl/abu_pkg.sv
package abu_pkg;
  localparam int BYTE_W = 8;
  localparam int DEF_SETS = 4;
  localparam int DEF_ADDR_W = 24;
  localparam int DEF_REG_AW = 4;
endpackage

// File: rtl/abu_regfile.sv
module abu_regfile #(
  parameter int N_SETS = abu_pkg::DEF_SETS,
  parameter int ADDR_W = abu_pkg::DEF_ADDR_W,
  parameter int REG_AW = abu_pkg::DEF_REG_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  output logic [N_SETS*ADDR_W-1:0] match_flat,
  output logic [N_SETS-1:0]        enables
);
  localparam int BYTES = ADDR_W / abu_pkg::BYTE_W;
  localparam int CTRL_ADDR = N_SETS * BYTES;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    logic [ADDR_W-1:0] set_q;
    always_ff @(posedge clk) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_en && wr_addr == REG_AW'(s * BYTES + b))
          set_q[b*8 +: 8] <= wr_data;
      end
    end
    assign match_flat[s*ADDR_W +: ADDR_W] = set_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enables <= '0;
    else if (wr_en && wr_addr == REG_AW'(CTRL_ADDR))
      enables <= wr_data[N_SETS-1:0];
  end
endmodule

// File: rtl/abu_addr_cmp.sv
module abu_addr_cmp #(
  parameter int N_SETS = abu_pkg::DEF_SETS,
  parameter int ADDR_W = abu_pkg::DEF_ADDR_W
) (
  input  logic                     mode_linear,
  input  logic [7:0]               base_byte,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     acc_valid,
  input  logic [N_SETS*ADDR_W-1:0] match_flat,
  input  logic [N_SETS-1:0]        enables,
  output logic [N_SETS-1:0]        hit
);
  localparam int LOW_W = ADDR_W - 8;
  logic [ADDR_W-1:0] eff_addr;

  assign eff_addr = mode_linear ? cpu_addr : {base_byte, cpu_addr[LOW_W-1:0]};

  for (genvar s = 0; s < N_SETS; s++) begin : g_cmp
    assign hit[s] = acc_valid && enables[s] &&
                    (eff_addr == match_flat[s*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/abu_brk_ctrl.sv
module abu_brk_ctrl #(
  parameter int N_SETS = abu_pkg::DEF_SETS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SETS-1:0] hit,
  input  logic              acc_first,
  input  logic              instr_end,
  input  logic              dbg_ack,
  output logic              brk_req,
  output logic [N_SETS-1:0] brk_hits
);
  logic [N_SETS-1:0] pend_q, live_hit, imm_hit, pend_all;
  logic              issue;

  assign live_hit = brk_req ? '0 : hit;
  assign imm_hit  = acc_first ? live_hit : '0;
  assign pend_all = pend_q | (acc_first ? '0 : live_hit);
  assign issue    = !brk_req && ((|imm_hit) || (instr_end && (|pend_all)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      brk_hits <= '0;
      pend_q   <= '0;
    end else if (issue) begin
      brk_req  <= 1'b1;
      brk_hits <= imm_hit | pend_all;
      pend_q   <= '0;
    end else begin
      if (brk_req && dbg_ack) brk_req <= 1'b0;
      pend_q <= pend_all;
    end
  end
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit #(
  parameter int N_SETS = abu_pkg::DEF_SETS,
  parameter int ADDR_W = abu_pkg::DEF_ADDR_W,
  parameter int REG_AW = abu_pkg::DEF_REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic              mode_linear,
  input  logic [7:0]        base_byte,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              acc_valid,
  input  logic              acc_first,
  input  logic              instr_end,
  input  logic              dbg_ack,
  output logic              brk_req,
  output logic [N_SETS-1:0] brk_hits
);
  logic [N_SETS*ADDR_W-1:0] match_w;
  logic [N_SETS-1:0]        en_w;
  logic [N_SETS-1:0]        hit_w;

  abu_regfile #(.N_SETS(N_SETS), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .match_flat(match_w), .enables(en_w)
  );

  abu_addr_cmp #(.N_SETS(N_SETS), .ADDR_W(ADDR_W)) u_cmp (
    .mode_linear(mode_linear), .base_byte(base_byte), .cpu_addr(cpu_addr),
    .acc_valid(acc_valid), .match_flat(match_w), .enables(en_w), .hit(hit_w)
  );

  abu_brk_ctrl #(.N_SETS(N_SETS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .acc_first(acc_first),
    .instr_end(instr_end), .dbg_ack(dbg_ack), .brk_req(brk_req),
    .brk_hits(brk_hits)
  );
endmodule

// File: rtl/abu_chk.sv
module abu_chk #(
  parameter int N_SETS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              brk_req,
  input logic [N_SETS-1:0] brk_hits,
  input logic              dbg_ack,
  input logic              acc_first,
  input logic [N_SETS-1:0] hit,
  input logic [N_SETS-1:0] enables
);
  // R6
  imm_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit) && acc_first && !brk_req) |=> brk_req);

  // R9
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !dbg_ack) |=> (brk_req && $stable(brk_hits)));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && dbg_ack) |=> !brk_req);

  // R8
  hits_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> (brk_hits != '0));

  // R5
  hits_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> ((brk_hits & ~$past(enables)) == '0));
endmodule

bind addr_brk_unit abu_chk #(.N_SETS(N_SETS)) u_abu_chk (
  .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .brk_hits(brk_hits),
  .dbg_ack(dbg_ack), .acc_first(acc_first), .hit(hit_w), .enables(en_w)
);

// File: tb/tb_addr_brk_unit.sv
module tb_addr_brk_unit;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0; logic [3:0] reg_wr_addr = 0; logic [7:0] reg_wr_data = 0;
  logic mode_linear = 1; logic [7:0] base_byte = 0; logic [23:0] cpu_addr = 0;
  logic acc_valid = 0, acc_first = 0, instr_end = 0, dbg_ack = 0;
  logic brk_req; logic [3:0] brk_hits;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R11";

  // reference model state
  logic [23:0] m_set [4];
  logic [3:0]  m_en = 0, m_pend = 0, m_hits = 0;
  logic        m_req = 0;

  always #2 clk = ~clk;

  addr_brk_unit dut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_hits = 0; m_req = 0;
    end else begin
      logic [23:0] eff; logic [3:0] h, imm, all;
      eff = mode_linear ? cpu_addr : {base_byte, cpu_addr[15:0]};
      h = 0;
      for (int i = 0; i < 4; i++)
        if (acc_valid && m_en[i] && eff == m_set[i]) h[i] = 1;
      if (m_req) begin
        if (dbg_ack) m_req = 0;
      end else begin
        imm = acc_first ? h : 4'h0;
        all = m_pend | (acc_first ? 4'h0 : h);
        if (imm != 0 || (instr_end && all != 0)) begin
          m_req = 1; m_hits = imm | all; m_pend = 0;
        end else m_pend = all;
      end
      if (reg_wr_en) begin
        if (reg_wr_addr < 12) m_set[reg_wr_addr/3][(reg_wr_addr%3)*8 +: 8] = reg_wr_data;
        else if (reg_wr_addr == 12) m_en = reg_wr_data[3:0];
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    checks++;
    if (brk_req !== m_req || brk_hits !== m_hits) begin
      errors++;
      $display("FAIL %s: actual req=%b hits=%b expected req=%b hits=%b",
               cur_req, brk_req, brk_hits, m_req, m_hits);
    end
    reg_wr_en = 0; acc_valid = 0; acc_first = 0; instr_end = 0; dbg_ack = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d; step();
  endtask

  task automatic wr_set(input int s, input logic [23:0] v);
    wr(4'(3*s), v[7:0]); wr(4'(3*s+1), v[15:8]); wr(4'(3*s+2), v[23:16]);
  endtask

  task automatic acc(input logic lin, input logic [7:0] b, input logic [23:0] a,
                     input logic ff, input logic ie);
    mode_linear = lin; base_byte = b; cpu_addr = a;
    acc_valid = 1; acc_first = ff; instr_end = ie; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ack();
    dbg_ack = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R11"; idle(2);
    cur_req = "R1";
    wr_set(0, 24'h123456); wr_set(1, 24'hAB1234);
    wr_set(2, 24'h7F0010); wr_set(3, 24'h000010);
    cur_req = "R2"; wr(4'hC, 8'hF1); wr(4'hD, 8'hFF); wr(4'hF, 8'h0E);
    cur_req = "R5"; acc(1, 0, 24'hAB1234, 1, 0); idle(2);
    cur_req = "R3"; acc(1, 0, 24'h123456, 1, 0);
    cur_req = "R6"; idle(1);
    cur_req = "R9"; idle(3);
    cur_req = "R10"; acc(1, 0, 24'h123456, 1, 1); acc(1, 0, 24'h123456, 0, 1);
    cur_req = "R9"; ack(); idle(2);
    cur_req = "R2"; wr(4'hC, 8'h0F);
    cur_req = "R4"; acc(0, 8'h7F, 24'hEE0010, 1, 0); idle(1); ack();
    acc(1, 0, 24'h7F0010, 1, 0); idle(1); ack();
    acc(0, 8'h12, 24'h993456, 1, 0); idle(1); ack();
    cur_req = "R7"; acc(1, 0, 24'h123456, 0, 0); idle(3);
    instr_end = 1; step(); idle(2); ack();
    acc(1, 0, 24'hAB1234, 0, 1); idle(1); ack();
    cur_req = "R8"; wr_set(1, 24'h000010);
    acc(0, 8'h00, 24'h550010, 1, 0); idle(1); ack();
    acc(1, 0, 24'h123456, 0, 0); acc(0, 8'h7F, 24'h000010, 0, 0);
    instr_end = 1; step(); idle(1); ack();
    cur_req = "R1"; wr(4'h0, 8'hAA); acc(1, 0, 24'h1234AA, 1, 0); idle(1); ack();
    acc(1, 0, 24'h123456, 1, 0); idle(1);
    cur_req = "R2"; wr(4'hC, 8'h00); ack(); acc(1, 0, 24'h1234AA, 1, 0); idle(2);
    cur_req = "R11"; wr(4'hC, 8'h01); acc(1, 0, 24'h1234AA, 0, 0);
    rst_n = 0; @(negedge clk); rst_n = 1;
    instr_end = 1; step(); idle(2);
    acc(1, 0, 24'h1234AA, 1, 0); idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule